// File: doc/BRIEF.md
# Debounced Pushbutton Pulse Sequencer

This block sits between three mechanical pushbuttons and the control pins of a downstream serial-in shift register. The buttons are shift, clear and latch. Each raw button line is first brought into the clock domain through a two-flop synchronizer. It is then qualified: a press counts only once the line has held its new level for a fixed quiet time, measured from its final transition. A press is therefore not taken on its first edge, and bounce or noise that settles back inside the quiet window produces nothing.

An accepted press starts a short, ordered run of one-cycle control pulses, so one press does several things downstream. A shift press gives a positive shift pulse and then a positive latch pulse. A clear press gives a low-going pulse on the active-low clear line and then a latch pulse. A latch press gives a single latch pulse. While a run is in progress, one further accepted press per button is held for later, and any press beyond that is discarded.

The quiet time is given in clock cycles. At 50 MHz, 16 ms is 800000 cycles, and that is the default. A test can set a small value instead.

Top module: `press_sequencer`

## Requirements
- R1: While reset is high, and on the cycle after reset is released, `shift_pulse_o` is 0, `clear_n_o` is 1 and `latch_pulse_o` is 0.
- R2: A raw level passes through two synchronizer flops. A press is accepted only after the synchronized line has been high for exactly QUIET_CYCLES consecutive clock samples. A raw high held for exactly QUIET_CYCLES cycles is accepted. The first pulse of the resulting run appears QUIET_CYCLES+3 rising edges after the first edge that captures the raw high.
- R3: Every change of the synchronized level restarts the stable count. A raw high that lasts QUIET_CYCLES-1 cycles or less produces no output pulse.
- R4: A press that bounces, with every bounce run shorter than QUIET_CYCLES and then a stable high, produces exactly one run.
- R5: An accepted shift press drives `shift_pulse_o` high for one cycle. GAP_CYCLES idle cycles follow (GAP_CYCLES >= 1), then `latch_pulse_o` goes high for one cycle.
- R6: An accepted clear press drives `clear_n_o` low for one cycle. GAP_CYCLES idle cycles follow, then `latch_pulse_o` goes high for one cycle.
- R7: An accepted latch press gives exactly one one-cycle `latch_pulse_o` pulse and nothing on the other outputs.
- R8: Only the press edge of the debounced level starts a run. The release edge starts nothing, even when the release bounces.
- R9: While a run is active or a press is waiting, each button holds one waiting press. Another accepted press on a button that already has one waiting is dropped.
- R10: Waiting presses start in priority order: clear first, then shift, then latch. After every latch pulse, one cycle passes with all outputs inactive before the next run starts.
- R11: At most one of the three outputs is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_shift_i | input | 1 | Raw shift button, high while pressed |
| raw_clear_i | input | 1 | Raw clear button, high while pressed |
| raw_latch_i | input | 1 | Raw latch button, high while pressed |
| shift_pulse_o | output | 1 | One-cycle positive shift pulse |
| clear_n_o | output | 1 | One-cycle active-low clear pulse |
| latch_pulse_o | output | 1 | One-cycle positive latch pulse |

## Verification
A high held for QUIET_CYCLES-1 cycles and one held for exactly QUIET_CYCLES cycles separate a quiet window that is too short or too long from the exact one. A bounced press followed by a bounced release shows that every transition restarts the count, and that the release edge is inert. Pressing all three buttons together checks the clear-shift-latch priority and the rest cycle between runs. Repeated presses on one button during a long run check the one-deep hold and the dropping of the extra press.

// File: rtl/press_seq_pkg.sv
package press_seq_pkg;
  localparam int NUM_BTN   = 3;
  localparam int BTN_SHIFT = 0;
  localparam int BTN_CLEAR = 1;
  localparam int BTN_LATCH = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_REST = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/quiet_filter.sv
module quiet_filter #(
  parameter int QUIET_CYCLES = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic level_o,
  output logic press_o
);
  localparam int CW = $clog2(QUIET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUIET_CYCLES - 1);

  logic          cand_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q  <= 1'b0;
      run_q   <= '0;
      level_o <= 1'b0;
      press_o <= 1'b0;
    end else begin
      press_o <= 1'b0;
      if (level_i != cand_q) begin
        cand_q <= level_i;
        run_q  <= CW'(1);
      end else if (cand_q != level_o) begin
        if (run_q == LAST) begin
          level_o <= cand_q;
          press_o <= cand_q;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pulse_sequencer.sv
module pulse_sequencer
  import press_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] press_i,
  output logic               shift_pulse_o,
  output logic               clear_n_o,
  output logic               latch_pulse_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  seq_state_e        state_q;
  logic [GW-1:0]     gap_q;
  logic [NUM_BTN-1:0] wait_q;
  logic [NUM_BTN-1:0] take;

  always_comb begin
    take = '0;
    if (state_q == SEQ_IDLE) begin
      if (wait_q[BTN_CLEAR])      take[BTN_CLEAR] = 1'b1;
      else if (wait_q[BTN_SHIFT]) take[BTN_SHIFT] = 1'b1;
      else if (wait_q[BTN_LATCH]) take[BTN_LATCH] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= SEQ_IDLE;
      gap_q         <= '0;
      wait_q        <= '0;
      shift_pulse_o <= 1'b0;
      clear_n_o     <= 1'b1;
      latch_pulse_o <= 1'b0;
    end else begin
      wait_q        <= (wait_q & ~take) | press_i;
      shift_pulse_o <= 1'b0;
      clear_n_o     <= 1'b1;
      latch_pulse_o <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          gap_q <= '0;
          if (take[BTN_CLEAR]) begin
            clear_n_o <= 1'b0;
            state_q   <= SEQ_GAP;
          end else if (take[BTN_SHIFT]) begin
            shift_pulse_o <= 1'b1;
            state_q       <= SEQ_GAP;
          end else if (take[BTN_LATCH]) begin
            latch_pulse_o <= 1'b1;
            state_q       <= SEQ_REST;
          end
        end
        SEQ_GAP: begin
          if (gap_q == GW'(GAP_CYCLES)) begin
            latch_pulse_o <= 1'b1;
            state_q       <= SEQ_REST;
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        SEQ_REST: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/press_sequencer.sv
module press_sequencer
  import press_seq_pkg::*;
#(
  parameter int QUIET_CYCLES = 800000,
  parameter int GAP_CYCLES   = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_shift_i,
  input  logic raw_clear_i,
  input  logic raw_latch_i,
  output logic shift_pulse_o,
  output logic clear_n_o,
  output logic latch_pulse_o
);
  logic [NUM_BTN-1:0] raw_vec;
  logic [NUM_BTN-1:0] synced;
  logic [NUM_BTN-1:0] steady;
  logic [NUM_BTN-1:0] press;

  always_comb begin
    raw_vec            = '0;
    raw_vec[BTN_SHIFT] = raw_shift_i;
    raw_vec[BTN_CLEAR] = raw_clear_i;
    raw_vec[BTN_LATCH] = raw_latch_i;
  end

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_i(raw_vec[b]), .q_o(synced[b])
    );
    quiet_filter #(.QUIET_CYCLES(QUIET_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .level_i(synced[b]),
      .level_o(steady[b]), .press_o(press[b])
    );
  end

  pulse_sequencer #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .press_i(press),
    .shift_pulse_o(shift_pulse_o), .clear_n_o(clear_n_o),
    .latch_pulse_o(latch_pulse_o)
  );
endmodule

// File: rtl/press_sequencer_chk.sv
module press_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic shift_pulse_o,
  input logic clear_n_o,
  input logic latch_pulse_o
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!shift_pulse_o && clear_n_o && !latch_pulse_o)); // R1

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({shift_pulse_o, !clear_n_o, latch_pulse_o}) <= 1); // R11

  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    shift_pulse_o |=> (!shift_pulse_o && !latch_pulse_o)); // R5

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !clear_n_o |=> (clear_n_o && !latch_pulse_o)); // R6

  AST_REST_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
    latch_pulse_o |=> (!latch_pulse_o && !shift_pulse_o && clear_n_o)); // R10
endmodule

bind press_sequencer press_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .shift_pulse_o(shift_pulse_o),
  .clear_n_o(clear_n_o), .latch_pulse_o(latch_pulse_o)
);

// File: tb/tb_press_sequencer.sv
module tb_press_sequencer;
  localparam int Q   = 20;
  localparam int GAP = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_shift = 1'b0, raw_clear = 1'b0, raw_latch = 1'b0;
  logic shift_o, clear_n, latch_o;

  int tests = 0, fails = 0;
  int n_shift = 0, n_clear = 0, n_latch = 0;
  int cyc = 0, first_clear = -1, first_shift = -1;
  bit started = 0;

  always #10 clk = ~clk;

  press_sequencer #(.QUIET_CYCLES(Q), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst(rst), .raw_shift_i(raw_shift), .raw_clear_i(raw_clear),
    .raw_latch_i(raw_latch), .shift_pulse_o(shift_o), .clear_n_o(clear_n),
    .latch_pulse_o(latch_o)
  );

  // behavioural reference: index 0 shift, 1 clear, 2 latch
  int m_s1[3], m_s2[3], m_val[3], m_len[3], m_deb[3], m_pq[3], m_wait[3];
  int m_state = 0, m_gap = 0;
  int e_shift = 0, e_clear_n = 1, e_latch = 0;

  always @(posedge clk) begin
    int raw[3];
    int np[3];
    int tk;
    started = 1;
    cyc++;
    raw[0] = raw_shift; raw[1] = raw_clear; raw[2] = raw_latch;
    if (rst) begin
      for (int b = 0; b < 3; b++) begin
        m_s1[b] = 0; m_s2[b] = 0; m_val[b] = 0; m_len[b] = 0;
        m_deb[b] = 0; m_pq[b] = 0; m_wait[b] = 0;
      end
      m_state = 0; m_gap = 0; e_shift = 0; e_clear_n = 1; e_latch = 0;
    end else begin
      for (int b = 0; b < 3; b++) begin
        np[b] = 0;
        if (m_s2[b] == m_val[b]) m_len[b]++;
        else begin m_val[b] = m_s2[b]; m_len[b] = 1; end
        if (m_len[b] == Q && m_val[b] != m_deb[b]) begin
          m_deb[b] = m_val[b]; np[b] = m_val[b];
        end
      end
      e_shift = 0; e_clear_n = 1; e_latch = 0; tk = -1;
      if (m_state == 0) begin
        m_gap = 0;
        if (m_wait[1] != 0) tk = 1;
        else if (m_wait[0] != 0) tk = 0;
        else if (m_wait[2] != 0) tk = 2;
        if (tk == 1) begin e_clear_n = 0; m_state = 1; end
        if (tk == 0) begin e_shift = 1; m_state = 1; end
        if (tk == 2) begin e_latch = 1; m_state = 2; end
      end else if (m_state == 1) begin
        if (m_gap == GAP) begin e_latch = 1; m_state = 2; end
        else m_gap++;
      end else m_state = 0;
      for (int b = 0; b < 3; b++) begin
        if (b == tk) m_wait[b] = 0;
        if (m_pq[b] != 0) m_wait[b] = 1;
        m_pq[b] = np[b];
        m_s2[b] = m_s1[b]; m_s1[b] = raw[b];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R5 shift_pulse_o vs model", shift_o, e_shift);
      chk("R6 clear_n_o vs model", clear_n, e_clear_n);
      chk("R7 latch_pulse_o vs model", latch_o, e_latch);
      if (shift_o) begin n_shift++; if (first_shift < 0) first_shift = cyc; end
      if (!clear_n) begin n_clear++; if (first_clear < 0) first_clear = cyc; end
      if (latch_o) n_latch++;
    end
  end

  task automatic drive(int s, int c, int l, int n);
    raw_shift = s[0]; raw_clear = c[0]; raw_latch = l[0];
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_shift = 0; n_clear = 0; n_latch = 0; first_clear = -1; first_shift = -1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset shift", shift_o, 0);
    chk("R1 reset clear_n", clear_n, 1);
    chk("R1 reset latch", latch_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release latch", latch_o, 0);
    clear_counts();

    // R2 clean shift press held long, R8 release ignored
    drive(1, 0, 0, 40); drive(0, 0, 0, 250);
    chk("R5 shift press shift pulses", n_shift, 1);
    chk("R5 shift press latch pulses", n_latch, 1);
    chk("R8 release adds nothing", n_clear, 0);
    clear_counts();

    // R6 clear press
    drive(0, 1, 0, 40); drive(0, 0, 0, 250);
    chk("R6 clear pulses", n_clear, 1);
    chk("R6 clear latch pulses", n_latch, 1);
    clear_counts();

    // R7 latch press alone
    drive(0, 0, 1, 40); drive(0, 0, 0, 60);
    chk("R7 latch only", n_latch, 1);
    chk("R7 no shift", n_shift, 0);
    clear_counts();

    // R3 glitch one cycle short of quiet time
    drive(1, 0, 0, Q - 1); drive(0, 0, 0, 80);
    chk("R3 short high ignored", n_shift + n_latch, 0);
    drive(0, 1, 0, 5); drive(0, 0, 0, 3); drive(0, 1, 0, 10); drive(0, 0, 0, 80);
    chk("R3 noise ignored", n_clear + n_latch, 0);
    clear_counts();

    // R2 exactly quiet time accepted
    drive(1, 0, 0, Q); drive(0, 0, 0, 250);
    chk("R2 exact quiet accepted", n_shift, 1);
    clear_counts();

    // R4 bouncing press and bouncing release (R8)
    drive(0, 1, 0, 3); drive(0, 0, 0, 2); drive(0, 1, 0, 5); drive(0, 0, 0, 1);
    drive(0, 1, 0, 8); drive(0, 0, 0, 4); drive(0, 1, 0, 30);
    drive(0, 0, 0, 3); drive(0, 1, 0, 2); drive(0, 0, 0, 250);
    chk("R4 bounced press one clear", n_clear, 1);
    chk("R8 bounced release one latch", n_latch, 1);
    clear_counts();

    // R10 simultaneous presses: clear, then shift, then latch
    drive(1, 1, 1, 30); drive(0, 0, 0, 700);
    chk("R10 clear count", n_clear, 1);
    chk("R10 shift count", n_shift, 1);
    chk("R10 latch count", n_latch, 3);
    chk("R10 clear before shift", (first_clear >= 0 && first_clear < first_shift) ? 1 : 0, 1);
    clear_counts();

    // R9 one waiting press kept, further one dropped
    drive(1, 0, 0, 25); drive(0, 0, 0, 25); drive(1, 0, 0, 25);
    drive(0, 0, 0, 25); drive(1, 0, 0, 25); drive(0, 0, 0, 500);
    chk("R9 held press runs, extra dropped", n_shift, 2);
    chk("R9 latch count", n_latch, 2);

    summary();
  end
endmodule